// File: doc/BRIEF.md
# Descriptor DMA control registers

This block is the control-register front end of a descriptor-driven Ethernet DMA engine. A CPU reaches it over a simple 32-bit register bus, with a write strobe, an address, write data and combinational read data. Through that bus the CPU stores where the transmit descriptor list and the receive descriptor list begin, and it can tell a suspended receive process to look again for free descriptors. The descriptor fetch logic, the frame path and the bus master are not part of the block. They appear only as single-cycle control inputs (start, stop, list exhausted), a descriptor-available level, and the two stored base addresses and per-process state codes that the block drives back to them.

The block keeps one state machine per direction. Each process is stopped, running or suspended. A process may be given a new list base only while it is stopped. If the base is written while the process is active, the write is dropped and a one-cycle reject pulse is raised. Stored bases always have their two low bits cleared, so every list starts on a 32-bit word. A write of any value to the receive start command offset matters only while the receive process is suspended. At that point the block samples the descriptor-available input. If a descriptor is free, the process returns to running and a one-cycle resume pulse is issued. If none is free, the process stays suspended until the next command.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset, both base addresses read as zero, both state outputs show stopped (code 0), and the reject and resume pulses are low.
- R2: A write to offset 0x10 (transmit list base) while the transmit process is stopped, or to offset 0x14 (receive list base) while the receive process is stopped, stores the write data with bits 1:0 cleared. The stored value appears on the base output and reads back at the same offset from the next cycle on.
- R3: A write to a base offset while its own process is running (code 1) or suspended (code 2) leaves the stored base unchanged and raises `base_wr_reject` for exactly the one cycle after the write.
- R4: Reads of the start command offset 0x0C, the reserved offsets 0x18 and 0x1C, and any unmapped offset return zero, even after a write to 0x0C.
- R5: The receive process goes from stopped to running on `rx_start` and from running to suspended on `rx_desc_empty`. `rx_stop` forces it to stopped from any state, and takes priority over every other input in the same cycle.
- R6: A write to 0x0C while the receive process is suspended and `rx_desc_avail` is high moves it to running in the next cycle. `rx_resume` is high for that one cycle only.
- R7: A write to 0x0C while the receive process is suspended and `rx_desc_avail` is low keeps it suspended, and `rx_resume` stays low.
- R8: A write to 0x0C while the receive process is stopped or running does not change its state and raises no resume pulse.
- R9: The transmit process goes from stopped to running on `tx_start` and from running to suspended on `tx_desc_empty`. From suspended, `tx_start` returns it to running and `tx_resume` pulses for one cycle. `tx_stop` forces it to stopped from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tx_start | input | 1 | Transmit start request pulse |
| tx_stop | input | 1 | Transmit stop request pulse |
| tx_desc_empty | input | 1 | Transmit list exhausted pulse |
| rx_start | input | 1 | Receive start request pulse |
| rx_stop | input | 1 | Receive stop request pulse |
| rx_desc_empty | input | 1 | Receive list exhausted pulse |
| rx_desc_avail | input | 1 | A receive descriptor is free (level) |
| tx_state | output | 2 | Transmit state: 0 stopped, 1 running, 2 suspended |
| rx_state | output | 2 | Receive state: 0 stopped, 1 running, 2 suspended |
| tx_resume | output | 1 | One-cycle pulse when transmit leaves suspended |
| rx_resume | output | 1 | One-cycle pulse when receive leaves suspended |
| tx_base_addr | output | 32 | Stored transmit list base |
| rx_base_addr | output | 32 | Stored receive list base |
| base_wr_reject | output | 1 | One-cycle pulse after a refused base write |

## Verification
The assertions assume that the bus carries at most one write per cycle. They also assume that the control pulses are one cycle wide and come from synchronous logic, so that a state change caused by a stop or start is visible before the next write is judged. The bench respects both assumptions. It drives every pulse and write for exactly one cycle, changes inputs only on the falling edge, and holds `rx_desc_avail` steady across each start command. It also never lets a base write coincide with a state change of the same process. The one deliberate overlap is a stop request in the same cycle as a start command, which exercises the stop priority.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    // Process state codes seen on the state outputs.
    typedef enum logic [1:0] {
        PROC_STOPPED   = 2'd0,
        PROC_RUNNING   = 2'd1,
        PROC_SUSPENDED = 2'd2
    } proc_state_e;

endpackage

// File: rtl/dma_proc_fsm.sv
module dma_proc_fsm
    import dma_ctl_pkg::*;
#(
    parameter bit KICK_RESUME = 1'b0   // 1: leave suspended on kick+avail, 0: on start
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        stop_i,
    input  logic        empty_i,
    input  logic        kick_i,
    input  logic        avail_i,
    output proc_state_e state_o,
    output logic        resume_o
);

    typedef struct packed {
        proc_state_e state;
        logic        resume;
    } fsm_t;

    fsm_t fsm_q, fsm_d;
    logic wake;

    generate
        if (KICK_RESUME) begin : g_kick
            assign wake = kick_i && avail_i;
        end else begin : g_start
            logic unused_kick;
            assign unused_kick = kick_i ^ avail_i;
            assign wake = start_i;
        end
    endgenerate

    always_comb begin
        fsm_d        = fsm_q;
        fsm_d.resume = 1'b0;
        if (stop_i) begin
            fsm_d.state = PROC_STOPPED;
        end else begin
            unique case (fsm_q.state)
                PROC_STOPPED: begin
                    if (start_i) fsm_d.state = PROC_RUNNING;
                end
                PROC_RUNNING: begin
                    if (empty_i) fsm_d.state = PROC_SUSPENDED;
                end
                PROC_SUSPENDED: begin
                    if (wake) begin
                        fsm_d.state  = PROC_RUNNING;
                        fsm_d.resume = 1'b1;
                    end
                end
                default: fsm_d.state = PROC_STOPPED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state  <= PROC_STOPPED;
            fsm_q.resume <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o  = fsm_q.state;
    assign resume_o = fsm_q.resume;

    // Stop request wins over everything (also covers the transmit side, R9).
    assert_stop_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> state_o == PROC_STOPPED);

    // A resume pulse only follows a suspended-to-running move.
    assert_resume_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> (state_o == PROC_RUNNING && $past(state_o) == PROC_SUSPENDED));

    generate
        if (KICK_RESUME) begin : g_kick_chk
            assert_dry_kick_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (state_o == PROC_SUSPENDED && kick_i && !avail_i && !stop_i)
                |=> (state_o == PROC_SUSPENDED && !resume_o));

            assert_kick_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (kick_i && state_o != PROC_SUSPENDED && !stop_i && !start_i && !empty_i)
                |=> (state_o == $past(state_o) && !resume_o));
        end
    endgenerate

endmodule

// File: rtl/dma_base_regs.sv
module dma_base_regs
    import dma_ctl_pkg::*;
#(
    parameter int unsigned              ADDR_W      = 8,
    parameter int unsigned              DATA_W      = 32,
    parameter int unsigned              ALIGN_BITS  = 2,
    parameter logic [ADDR_W-1:0]        CMD_OFS     = 8'h0C,
    parameter logic [ADDR_W-1:0]        TX_BASE_OFS = 8'h10,
    parameter logic [ADDR_W-1:0]        RX_BASE_OFS = 8'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  proc_state_e       tx_state_i,
    input  proc_state_e       rx_state_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] tx_base_o,
    output logic [DATA_W-1:0] rx_base_o,
    output logic              reject_o,
    output logic              kick_o
);

    localparam int unsigned       LISTS      = 2;
    localparam logic [DATA_W-1:0] ALIGN_MASK = {{(DATA_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

    typedef struct packed {
        logic [LISTS-1:0][DATA_W-1:0] base;
        logic                         reject;
    } regs_t;

    regs_t regs_q, regs_d;
    logic [LISTS-1:0] slot_hit;
    logic [LISTS-1:0] slot_open;

    // Slot 0 is the transmit list, slot 1 the receive list.
    generate
        for (genvar i = 0; i < LISTS; i++) begin : g_slot
            localparam logic [ADDR_W-1:0] SLOT_OFS = (i == 0) ? TX_BASE_OFS : RX_BASE_OFS;
            assign slot_hit[i]  = wr_en_i && (addr_i == SLOT_OFS);
            assign slot_open[i] = ((i == 0) ? tx_state_i : rx_state_i) == PROC_STOPPED;
        end
    endgenerate

    always_comb begin
        regs_d        = regs_q;
        regs_d.reject = 1'b0;
        for (int i = 0; i < LISTS; i++) begin
            if (slot_hit[i]) begin
                if (slot_open[i]) regs_d.base[i] = wdata_i & ALIGN_MASK;
                else              regs_d.reject  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Read mux: command, reserved and unmapped offsets all return zero.
    always_comb begin
        rdata_o = '0;
        if (addr_i == TX_BASE_OFS)      rdata_o = regs_q.base[0];
        else if (addr_i == RX_BASE_OFS) rdata_o = regs_q.base[1];
    end

    assign tx_base_o = regs_q.base[0];
    assign rx_base_o = regs_q.base[1];
    assign reject_o  = regs_q.reject;
    assign kick_o    = wr_en_i && (addr_i == CMD_OFS);

    assert_tx_open_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == TX_BASE_OFS && tx_state_i == PROC_STOPPED)
        |=> (tx_base_o == ($past(wdata_i) & ALIGN_MASK) && !reject_o));

    assert_rx_open_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == RX_BASE_OFS && rx_state_i == PROC_STOPPED)
        |=> (rx_base_o == ($past(wdata_i) & ALIGN_MASK) && !reject_o));

    assert_tx_locked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == TX_BASE_OFS && tx_state_i != PROC_STOPPED)
        |=> ($stable(tx_base_o) && reject_o));

    assert_rx_locked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == RX_BASE_OFS && rx_state_i != PROC_STOPPED)
        |=> ($stable(rx_base_o) && reject_o));

    assert_reject_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |-> $past(wr_en_i));

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_ctl_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 8,
    parameter int unsigned       DATA_W      = 32,
    parameter int unsigned       ALIGN_BITS  = 2,
    parameter logic [ADDR_W-1:0] CMD_OFS     = 8'h0C,
    parameter logic [ADDR_W-1:0] TX_BASE_OFS = 8'h10,
    parameter logic [ADDR_W-1:0] RX_BASE_OFS = 8'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tx_start,
    input  logic              tx_stop,
    input  logic              tx_desc_empty,
    input  logic              rx_start,
    input  logic              rx_stop,
    input  logic              rx_desc_empty,
    input  logic              rx_desc_avail,
    output logic [1:0]        tx_state,
    output logic [1:0]        rx_state,
    output logic              tx_resume,
    output logic              rx_resume,
    output logic [DATA_W-1:0] tx_base_addr,
    output logic [DATA_W-1:0] rx_base_addr,
    output logic              base_wr_reject
);

    proc_state_e tx_state_w, rx_state_w;
    logic        rx_kick;

    dma_base_regs #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .ALIGN_BITS  (ALIGN_BITS),
        .CMD_OFS     (CMD_OFS),
        .TX_BASE_OFS (TX_BASE_OFS),
        .RX_BASE_OFS (RX_BASE_OFS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr),
        .wr_en_i    (reg_wr_en),
        .wdata_i    (reg_wdata),
        .tx_state_i (tx_state_w),
        .rx_state_i (rx_state_w),
        .rdata_o    (reg_rdata),
        .tx_base_o  (tx_base_addr),
        .rx_base_o  (rx_base_addr),
        .reject_o   (base_wr_reject),
        .kick_o     (rx_kick)
    );

    dma_proc_fsm #(.KICK_RESUME(1'b0)) u_tx_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (tx_start),
        .stop_i   (tx_stop),
        .empty_i  (tx_desc_empty),
        .kick_i   (1'b0),
        .avail_i  (1'b0),
        .state_o  (tx_state_w),
        .resume_o (tx_resume)
    );

    dma_proc_fsm #(.KICK_RESUME(1'b1)) u_rx_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (rx_start),
        .stop_i   (rx_stop),
        .empty_i  (rx_desc_empty),
        .kick_i   (rx_kick),
        .avail_i  (rx_desc_avail),
        .state_o  (rx_state_w),
        .resume_o (rx_resume)
    );

    assign tx_state = tx_state_w;
    assign rx_state = rx_state_w;

endmodule

// File: tb/tb_dma_ctl_regs.sv
module tb_dma_ctl_regs;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_start = 0, tx_stop = 0, tx_desc_empty = 0;
    logic        rx_start = 0, rx_stop = 0, rx_desc_empty = 0, rx_desc_avail = 0;
    logic [1:0]  tx_state, rx_state;
    logic        tx_resume, rx_resume, base_wr_reject;
    logic [31:0] tx_base_addr, rx_base_addr;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_ctl_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_start(tx_start),
        .tx_stop(tx_stop), .tx_desc_empty(tx_desc_empty), .rx_start(rx_start),
        .rx_stop(rx_stop), .rx_desc_empty(rx_desc_empty), .rx_desc_avail(rx_desc_avail),
        .tx_state(tx_state), .rx_state(rx_state), .tx_resume(tx_resume),
        .rx_resume(rx_resume), .tx_base_addr(tx_base_addr), .rx_base_addr(rx_base_addr),
        .base_wr_reject(base_wr_reject)
    );

    // Vector: {kind(2): 0 write / 1 read-check, addr(8), data(32), expect(32), req(4)}
    localparam int NVEC = 10;
    localparam logic [77:0] VEC [NVEC] = '{
        {2'd0, 8'h10, 32'h1234_5677, 32'h0, 4'd2},
        {2'd1, 8'h10, 32'h0, 32'h1234_5674, 4'd2},
        {2'd0, 8'h14, 32'hDEAD_BEEF, 32'h0, 4'd2},
        {2'd1, 8'h14, 32'h0, 32'hDEAD_BEEC, 4'd2},
        {2'd1, 8'h0C, 32'h0, 32'h0, 4'd4},
        {2'd1, 8'h18, 32'h0, 32'h0, 4'd4},
        {2'd1, 8'h1C, 32'h0, 32'h0, 4'd4},
        {2'd0, 8'h0C, 32'hFFFF_FFFF, 32'h0, 4'd4},
        {2'd1, 8'h0C, 32'h0, 32'h0, 4'd4},
        {2'd1, 8'h24, 32'h0, 32'h0, 4'd4}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata, exp, req);
    endtask

    // ctl bits: {tx_start, tx_stop, tx_desc_empty, rx_start, rx_stop, rx_desc_empty}
    task automatic pulse(input logic [5:0] c);
        @(negedge clk);
        {tx_start, tx_stop, tx_desc_empty, rx_start, rx_stop, rx_desc_empty} = c;
        @(negedge clk);
        {tx_start, tx_stop, tx_desc_empty, rx_start, rx_stop, rx_desc_empty} = '0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check({30'd0, tx_state}, 32'd0, "R1 tx_state");
        check({30'd0, rx_state}, 32'd0, "R1 rx_state");
        check(tx_base_addr, 32'd0, "R1 tx_base");
        check(rx_base_addr, 32'd0, "R1 rx_base");
        check({29'd0, base_wr_reject, tx_resume, rx_resume}, 32'd0, "R1 pulses");

        // Table walk: bases stored aligned (R2), zero reads (R4)
        for (int i = 0; i < NVEC; i++) begin
            logic [77:0] v;
            v = VEC[i];
            if (v[77:76] == 2'd0) wr(v[75:68], v[67:36]);
            else rd(v[75:68], v[35:4], $sformatf("R%0d vec%0d", v[3:0], i));
        end
        check(tx_base_addr, 32'h1234_5674, "R2 tx_base port");
        check(rx_base_addr, 32'hDEAD_BEEC, "R2 rx_base port");

        // Transmit process (R9) and locked write (R3)
        pulse(6'b100000);
        check({30'd0, tx_state}, 32'd1, "R9 tx start");
        wr(8'h10, 32'hAAAA_0000);
        check({31'd0, base_wr_reject}, 32'd1, "R3 reject pulse");
        rd(8'h10, 32'h1234_5674, "R3 tx base kept");
        check({31'd0, base_wr_reject}, 32'd0, "R3 reject one cycle");
        wr(8'h14, 32'h0000_0103);
        check({31'd0, base_wr_reject}, 32'd0, "R2 rx open while tx busy");
        check(rx_base_addr, 32'h0000_0100, "R2 rx base aligned");
        pulse(6'b001000);
        check({30'd0, tx_state}, 32'd2, "R9 tx suspend");
        wr(8'h10, 32'h5555_0000);
        check({31'd0, base_wr_reject}, 32'd1, "R3 reject in suspended");
        check(tx_base_addr, 32'h1234_5674, "R3 tx base kept suspended");
        pulse(6'b100000);
        check({30'd0, tx_state}, 32'd1, "R9 tx resume state");
        check({31'd0, tx_resume}, 32'd1, "R9 tx_resume pulse");
        pulse(6'b010000);
        check({30'd0, tx_state}, 32'd0, "R9 tx stop");

        // Receive process
        wr(8'h0C, 32'h0);
        check({30'd0, rx_state}, 32'd0, "R8 cmd while stopped");
        pulse(6'b000100);
        check({30'd0, rx_state}, 32'd1, "R5 rx start");
        wr(8'h0C, 32'h1);
        check({30'd0, rx_state}, 32'd1, "R8 cmd while running");
        check({31'd0, rx_resume}, 32'd0, "R8 no resume");
        pulse(6'b000001);
        check({30'd0, rx_state}, 32'd2, "R5 rx suspend");
        rx_desc_avail = 1'b0;
        wr(8'h0C, 32'h7);
        check({30'd0, rx_state}, 32'd2, "R7 stays suspended");
        check({31'd0, rx_resume}, 32'd0, "R7 no resume");
        rx_desc_avail = 1'b1;
        wr(8'h0C, 32'h0);
        check({30'd0, rx_state}, 32'd1, "R6 resumed");
        check({31'd0, rx_resume}, 32'd1, "R6 resume pulse");
        @(negedge clk);
        check({31'd0, rx_resume}, 32'd0, "R6 resume one cycle");
        wr(8'h14, 32'hFFFF_FFFF);
        check({31'd0, base_wr_reject}, 32'd1, "R3 rx reject");
        check(rx_base_addr, 32'h0000_0100, "R3 rx base kept");
        pulse(6'b000001);
        check({30'd0, rx_state}, 32'd2, "R5 rx suspend again");
        @(negedge clk);
        rx_stop = 1'b1; reg_addr = 8'h0C; reg_wr_en = 1'b1;
        @(negedge clk);
        rx_stop = 1'b0; reg_wr_en = 1'b0;
        check({30'd0, rx_state}, 32'd0, "R5 stop beats command");
        check({31'd0, rx_resume}, 32'd0, "R5 no resume on stop");
        pulse(6'b000100);
        pulse(6'b000010);
        check({30'd0, rx_state}, 32'd0, "R5 stop from running");
        wr(8'h14, 32'h0000_2002);
        check(rx_base_addr, 32'h0000_2000, "R2 rx base after stop");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule